// File: doc/BRIEF.md
# Serial ADC Host Controller

This block sits on the host side of a 14-bit serial sampling converter. It drives the convert strobe and the serial clock, and it shifts the returned sample in from the converter's data line. A host asks for one action at a time through a request/acknowledge handshake with a two-bit mode code. The four actions are a single conversion, a light power-down, a deep power-down and a wake-up.

A rising convert strobe samples the input and starts a conversion. The converter launches each data bit on a rising serial clock edge. The block samples the data line on the following falling edge. A frame lasts 16 serial clock periods. The first two bits are padding, and the next 14 bits carry the result, most significant bit first.

Each word reports the sample taken at the previous conversion. For that reason the valid flag is pipelined by one frame. Power-down is requested by sending convert pulses while the serial clock is parked low. A wake runs a set number of throw-away frames before the block reports valid data again.

Top module: `adc_serial_host`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `req_ack` is 1, `conv_o`, `sclk_o` and `res_valid` are 0, and `pwr_state` is 0 (active).
- R2: A request is taken on a clock edge where `req_valid` and `req_ack` are both 1. `req_ack` is 0 from the next cycle and stays 0 for the whole sequence, which takes exactly its nominal number of cycles. A `req_valid` held high during that time starts nothing further.
- R3: Mode 0 (convert) runs one frame. `conv_o` rises on the accept edge and stays high for exactly one serial period of 2*HALF_DIV clocks. `sclk_o` makes 16 pulses, one every 2*HALF_DIV clocks. Each pulse is low for the first HALF_DIV clocks of its period and high for the second HALF_DIV clocks.
- R4: `sdi_i` is sampled at each falling `sclk_o` edge. Samples 3 to 16 of a frame form `res_data`, MSB first. The first two samples, and the line level outside frames, have no effect on the result.
- R5: `res_valid` is a one-cycle pulse on the cycle after the last falling edge of a convert frame. It is given only if another frame has completed since the last reset or power-down command. The first convert after reset gives no pulse.
- R6: Mode 1 (light power-down) sends 2 `conv_o` pulses. Each pulse is one serial period wide and is followed by GAP_PER low periods. `sclk_o` stays 0 throughout, and `pwr_state` then reads 1.
- R7: Mode 2 (deep power-down) sends 4 pulses with the same shape, `sclk_o` stays 0, and `pwr_state` then reads 2.
- R8: Mode 3 (wake) runs WAKE_FRAMES full frames with serial clock pulses and gives no `res_valid`. Afterwards `pwr_state` reads 0, and the next convert is reported valid.
- R9: After a power-down command, the first convert gives no `res_valid` and returns `pwr_state` to 0. The second convert is valid.
- R10: `pwr_state` never reads 3, and it changes only on the cycle where `req_ack` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request pending |
| req_mode | input | 2 | 0 convert, 1 light power-down, 2 deep power-down, 3 wake |
| req_ack | output | 1 | High when idle; a request is taken when both are high |
| conv_o | output | 1 | Convert strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe for a valid result |
| res_data | output | DATA_W | Captured result word |
| pwr_state | output | 2 | Believed converter mode: 0 active, 1 light, 2 deep |

## Verification
Several events land on the same clock edge when a sequence finishes. The last falling serial edge, the result strobe, the mode update and the return of `req_ack` all happen together. A request that is still held would be taken on the very next edge. The bench provokes this by holding `req_valid` high through whole sequences and releasing it only once the acknowledge is back. It then checks four things: exactly one convert-strobe rise per single-frame sequence, the exact number of low-acknowledge cycles, one result pulse carrying the right word, and the expected mode code.

// File: rtl/ahc_pkg.sv
package ahc_pkg;
  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_LIGHT = 2'd1,
    OP_DEEP  = 2'd2,
    OP_WAKE  = 2'd3
  } ahc_op_e;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_LIGHT  = 2'd1,
    PM_DEEP   = 2'd2
  } ahc_pm_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_PWR
  } ahc_st_e;
endpackage

// File: rtl/ahc_bit_timer.sv
// Phase counter inside one serial clock period.
module ahc_bit_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mid_tick,
  output logic end_tick
);
  localparam int PER_CYC = 2 * HALF_DIV;
  localparam int PH_W    = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph <= '0;
    end else if (ph == PH_W'(PER_CYC - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign mid_tick = run && (ph == PH_W'(HALF_DIV - 1));
  assign end_tick = run && (ph == PH_W'(PER_CYC - 1));
endmodule

// File: rtl/ahc_shift_in.sv
// Serial-in shifter; nxt is the word including the bit being sampled now.
module ahc_shift_in #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              sdi,
  output logic [DATA_W-1:0] nxt
);
  logic [DATA_W-2:0] sh;

  assign nxt = {sh, sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (cap) begin
      sh <= nxt[DATA_W-2:0];
    end
  end
endmodule

// File: rtl/ahc_seq.sv
// Sequencer: frames, power-mode pulse trains, valid pipelining, mode tracking.
module ahc_seq
  import ahc_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int LEAD_W       = 2,
  parameter int GAP_PER      = 2,
  parameter int WAKE_FRAMES  = 1,
  parameter int LIGHT_PULSES = 2,
  parameter int DEEP_PULSES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  output logic              req_ack,
  input  logic              mid_tick,
  input  logic              end_tick,
  output logic              run,
  output logic              cap,
  input  logic [DATA_W-1:0] word_nxt,
  output logic              conv_o,
  output logic              sclk_o,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [1:0]        pwr_state
);
  localparam int FRAME_W = LEAD_W + DATA_W;
  localparam int PER_MAX = (FRAME_W > GAP_PER + 1) ? FRAME_W : GAP_PER + 1;
  localparam int PER_W   = $clog2(PER_MAX);
  localparam int PUL_MAX = (DEEP_PULSES > LIGHT_PULSES) ? DEEP_PULSES : LIGHT_PULSES;
  localparam int CNT_MAX = (WAKE_FRAMES > PUL_MAX) ? WAKE_FRAMES : PUL_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ahc_st_e           state;
  ahc_op_e           op;
  ahc_pm_e           pm_q;
  logic [PER_W-1:0]  per;
  logic [CNT_W-1:0]  cnt;
  logic              conv_q, sclk_q, ack_q, primed, vld_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              last_per_frame, last_per_slot;

  assign accept         = req_valid && ack_q;
  assign run            = (state != ST_IDLE);
  assign cap            = end_tick && (state == ST_FRAME);
  assign last_per_frame = (per == PER_W'(FRAME_W - 1));
  assign last_per_slot  = (per == PER_W'(GAP_PER));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op     <= OP_CONV;
      pm_q   <= PM_ACTIVE;
      per    <= '0;
      cnt    <= '0;
      conv_q <= 1'b0;
      sclk_q <= 1'b0;
      ack_q  <= 1'b1;
      primed <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op     <= ahc_op_e'(req_mode);
            per    <= '0;
            conv_q <= 1'b1;
            ack_q  <= 1'b0;
            case (ahc_op_e'(req_mode))
              OP_CONV: begin
                state <= ST_FRAME;
                cnt   <= '0;
              end
              OP_WAKE: begin
                state <= ST_FRAME;
                cnt   <= CNT_W'(WAKE_FRAMES - 1);
              end
              OP_LIGHT: begin
                state  <= ST_PWR;
                cnt    <= CNT_W'(LIGHT_PULSES - 1);
                primed <= 1'b0;
              end
              default: begin
                state  <= ST_PWR;
                cnt    <= CNT_W'(DEEP_PULSES - 1);
                primed <= 1'b0;
              end
            endcase
          end
        end
        ST_FRAME: begin
          if (mid_tick) sclk_q <= 1'b1;
          if (end_tick) begin
            sclk_q <= 1'b0;
            if (per == '0) conv_q <= 1'b0;
            if (last_per_frame) begin
              primed <= 1'b1;
              if (op == OP_CONV) begin
                vld_q  <= primed;
                data_q <= word_nxt;
              end
              if (cnt != '0) begin
                cnt    <= cnt - 1'b1;
                per    <= '0;
                conv_q <= 1'b1;
              end else begin
                state <= ST_IDLE;
                ack_q <= 1'b1;
                pm_q  <= PM_ACTIVE;
              end
            end else begin
              per <= per + 1'b1;
            end
          end
        end
        ST_PWR: begin
          if (end_tick) begin
            if (per == '0) conv_q <= 1'b0;
            if (last_per_slot) begin
              if (cnt != '0) begin
                cnt    <= cnt - 1'b1;
                per    <= '0;
                conv_q <= 1'b1;
              end else begin
                state <= ST_IDLE;
                ack_q <= 1'b1;
                pm_q  <= (op == OP_LIGHT) ? PM_LIGHT : PM_DEEP;
              end
            end else begin
              per <= per + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ack   = ack_q;
  assign conv_o    = conv_q;
  assign sclk_o    = sclk_q;
  assign res_valid = vld_q;
  assign res_data  = data_q;
  assign pwr_state = pm_q;
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host #(
  parameter int HALF_DIV     = 2,
  parameter int GAP_PER      = 2,
  parameter int WAKE_FRAMES  = 1,
  parameter int DATA_W       = 14,
  parameter int LEAD_W       = 2,
  parameter int LIGHT_PULSES = 2,
  parameter int DEEP_PULSES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  output logic              req_ack,
  output logic              conv_o,
  output logic              sclk_o,
  input  logic              sdi_i,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [1:0]        pwr_state
);
  logic              run, mid_tick, end_tick, cap;
  logic [DATA_W-1:0] word_nxt;

  ahc_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mid_tick (mid_tick),
    .end_tick (end_tick)
  );

  ahc_shift_in #(.DATA_W(DATA_W)) u_shift (
    .clk (clk),
    .rst (rst),
    .cap (cap),
    .sdi (sdi_i),
    .nxt (word_nxt)
  );

  ahc_seq #(
    .DATA_W       (DATA_W),
    .LEAD_W       (LEAD_W),
    .GAP_PER      (GAP_PER),
    .WAKE_FRAMES  (WAKE_FRAMES),
    .LIGHT_PULSES (LIGHT_PULSES),
    .DEEP_PULSES  (DEEP_PULSES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_ack   (req_ack),
    .mid_tick  (mid_tick),
    .end_tick  (end_tick),
    .run       (run),
    .cap       (cap),
    .word_nxt  (word_nxt),
    .conv_o    (conv_o),
    .sclk_o    (sclk_o),
    .res_valid (res_valid),
    .res_data  (res_data),
    .pwr_state (pwr_state)
  );
endmodule

// File: rtl/ahc_checker.sv
module ahc_checker #(
  parameter int HALF_DIV = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ack,
  input logic       conv_o,
  input logic       sclk_o,
  input logic       res_valid,
  input logic [1:0] pwr_state
);
  int conv_run;

  always_ff @(posedge clk) begin
    if (rst || !conv_o) conv_run <= 0;
    else                conv_run <= conv_run + 1;
  end

  // R3: convert strobe width is one serial period
  a_r3_conv_width: assert property (@(posedge clk) disable iff (rst)
    (!conv_o && $past(conv_o)) |-> (conv_run == 2 * HALF_DIV));

  // R2: strobes only move while the host is held off
  a_r2_conv_busy: assert property (@(posedge clk) disable iff (rst)
    conv_o |-> !req_ack);

  a_r2_sclk_busy: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !req_ack);

  // R5: result strobe is a single cycle right after a falling serial edge
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r5_valid_after_fall: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (!sclk_o && $past(sclk_o)));

  // R10: legal mode code, updated only at sequence completion
  a_r10_pm_legal: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'd3);

  a_r10_pm_change_on_done: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != $past(pwr_state)) |-> (req_ack && !$past(req_ack)));
endmodule

bind adc_serial_host ahc_checker #(.HALF_DIV(HALF_DIV)) u_ahc_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ack   (req_ack),
  .conv_o    (conv_o),
  .sclk_o    (sclk_o),
  .res_valid (res_valid),
  .pwr_state (pwr_state)
);

// File: tb/test_adc_serial_host.sv
`timescale 1ns/1ps
module test_adc_serial_host;
  localparam int H   = 2;
  localparam int GAP = 2;
  localparam int WF  = 2;
  localparam int FW  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic        req_ack, conv_o, sclk_o, res_valid;
  logic        sdi = 1'b0;
  logic [13:0] res_data;
  logic [1:0]  pwr_state;

  int nchk = 0, nerr = 0;
  int tick = 0, ack_low = 0, n_cr = 0, n_sr = 0, n_v = 0, bad_t = 0;
  int conv_hi = 0, t_cr = 0, t_sr = 0;
  logic p_conv = 1'b0, p_sclk = 1'b0;
  logic [13:0] got = '0;
  logic [13:0] fw = '0;
  int bidx = 0;
  bit primed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_host #(.HALF_DIV(H), .GAP_PER(GAP), .WAKE_FRAMES(WF)) i_adc_serial_host (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_ack(req_ack), .conv_o(conv_o), .sclk_o(sclk_o), .sdi_i(sdi),
    .res_valid(res_valid), .res_data(res_data), .pwr_state(pwr_state));

  // converter model: launches on rising serial edge, padding bits are junk
  always @(posedge sclk_o) begin
    if (conv_o) begin
      bidx = 0;
      fw = 14'($urandom);
    end
    if (bidx < 2) sdi = 1'($urandom);
    else          sdi = fw[15 - bidx];
    bidx++;
  end

  always @(negedge clk) begin
    if (!rst) begin
      tick++;
      if (!req_ack) ack_low++;
      if (conv_o && !p_conv) begin n_cr++; t_cr = tick; end
      if (conv_o) conv_hi++;
      if (!conv_o && p_conv) begin
        if (conv_hi != 2 * H) bad_t++;
        conv_hi = 0;
      end
      if (sclk_o && !p_sclk) begin
        if (n_sr > 0 && (tick - t_sr) != 2 * H) bad_t++;
        if (conv_o && (tick - t_cr) != H) bad_t++;
        n_sr++;
        t_sr = tick;
      end
      if (res_valid) begin n_v++; got = res_data; end
      p_conv = conv_o;
      p_sclk = sclk_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dur(input int m);
    case (m)
      0: return FW * 2 * H;
      1: return 2 * (GAP + 1) * 2 * H;
      2: return 4 * (GAP + 1) * 2 * H;
      default: return WF * FW * 2 * H;
    endcase
  endfunction

  function automatic int exp_pulses(input int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return WF;
    endcase
  endfunction

  function automatic int exp_pm(input int m);
    if (m == 1) return 1;
    if (m == 2) return 2;
    return 0;
  endfunction

  task automatic do_op(input int m, input bit hold);
    int ev;
    @(negedge clk);
    while (!req_ack) @(negedge clk);
    ack_low = 0; n_cr = 0; n_sr = 0; n_v = 0; bad_t = 0;
    req_valid = 1'b1;
    req_mode = 2'(m);
    @(negedge clk);
    chk("R2 ack low after accept", int'(req_ack), 0);
    if (!hold) req_valid = 1'b0;
    while (!req_ack) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    ev = (m == 0) ? int'(primed) : 0;
    if (m == 0 || m == 3) primed = 1;
    else primed = 0;
    chk("R2 busy cycles", ack_low, exp_dur(m));
    chk("R3 R6 R7 R8 convert pulses", n_cr, exp_pulses(m));
    chk("R3 R6 R7 R8 serial pulses", n_sr, (m == 0) ? FW : (m == 3) ? WF * FW : 0);
    chk("R3 strobe timing", bad_t, 0);
    chk("R5 R8 R9 valid count", n_v, ev);
    if (ev == 1) chk("R4 result word", int'(got), int'(fw));
    chk("R6 R7 R10 mode", int'(pwr_state), exp_pm(m));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R2 watchdog actual=hung expected=idle");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1403));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ack in reset", int'(req_ack), 1);
    chk("R1 conv in reset", int'(conv_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack", int'(req_ack), 1);
    chk("R1 conv", int'(conv_o), 0);
    chk("R1 sclk", int'(sclk_o), 0);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 mode", int'(pwr_state), 0);
    do_op(0, 0);          // R5 first after reset invalid
    do_op(0, 1);          // R2 held request, R4
    do_op(0, 0);
    do_op(1, 0);          // R6
    do_op(0, 0);          // R9 first after power-down invalid
    do_op(0, 1);          // R9 second valid
    do_op(2, 1);          // R7
    do_op(3, 0);          // R8
    do_op(0, 0);          // R8 valid after wake
    for (int i = 0; i < 40; i++) do_op(int'($urandom % 4), bit'($urandom % 2));
    finish_run();
  end
endmodule